// File: doc/BRIEF.md
# Prescaled Timer Counter with Selectable Count Source

The block holds a free-running timer counter that a prescale stage feeds. Each qualifying event advances the prescale counter. The timer counter advances once the prescale counter has passed its programmed limit. A qualifying event is one of two kinds, chosen by a 2-bit source mode. In clock mode it is every clock cycle. In the three edge modes it is a rising, falling or either-direction edge on one capture input, picked by a select field. Every capture input first passes through a two-flop synchronizer. The control fields are plain ports that a register file elsewhere drives. Downstream match and capture logic receives the counter value and a one-cycle advance strobe. It can return a clear request and a stop request, which act on the advance the strobe announced.

A small run-control state machine orders these controls. Its states are `ST_IDLE`, `ST_COUNT`, `ST_HALT` and `ST_CLEAR`.
- Any state goes to `ST_CLEAR` while the counter-reset input is high.
- Leaving `ST_CLEAR`, `ST_IDLE` or `ST_COUNT` leads to `ST_IDLE` when enable is low.
- From those same states, an advance that arrives with the stop request leads to `ST_HALT`. Otherwise the machine goes to `ST_COUNT`.
- `ST_HALT` holds until enable drops, which leads to `ST_IDLE`.

Counting is allowed in a cycle when enable is high, counter reset is low and the state is not `ST_HALT`.

Top module: `prescaled_timer`

## Requirements
- R1: After the asynchronous reset, `count_value` is 0 and `count_tick` is 0.
- R2: In source mode 0 (clock), with prescale 0 and enable high, `count_value` increases by one at every clock edge.
- R3: The prescale counter advances on each qualifying event. When it is already greater than or equal to `cfg_prescale` it returns to 0 instead, and the timer counter advances. The timer therefore moves once per `cfg_prescale`+1 events.
- R4: Source mode 1 counts rising edges, mode 2 falling edges and mode 3 both edges of the selected input. An input change present before clock edge k becomes a qualifying event in the cycle after edge k+1.
- R5: `cfg_src_sel` holds the index of the capture input that edge modes watch, with 0 selecting `cap_in[0]`. Edges on the other inputs have no effect.
- R6: With enable low, both the timer counter and the prescale counter hold their values. Counting resumes from them when enable returns.
- R7: While `cnt_clr` is high, both counters are 0 from the next clock edge on. `cnt_clr` overrides enable, the events and both match requests.
- R8: The timer counter wraps from its all-ones value to 0 and has no other effect.
- R9: `count_tick` is high in exactly those cycles whose following clock edge advances the timer counter.
- R10: `match_clr` high in a cycle with `count_tick` high loads 0 into the timer counter in place of the increment. In any other cycle it has no effect.
- R11: `match_stop` high in a cycle with `count_tick` high lets that advance happen and then freezes counting (`ST_HALT`) until enable is taken low. In any other cycle it has no effect.
- R12: In source mode 0 the capture inputs and `cfg_src_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Source mode: 0 clock, 1 rising, 2 falling, 3 both edges |
| cfg_src_sel | input | $clog2(NUM_CH) | Index of the capture input used in edge modes |
| cfg_prescale | input | CNT_W | Prescale limit |
| cnt_en | input | 1 | Count enable |
| cnt_clr | input | 1 | Synchronous clear of both counters, level held |
| cap_in | input | NUM_CH | Asynchronous capture inputs |
| match_clr | input | 1 | Clear request from match logic, acts on a tick cycle |
| match_stop | input | 1 | Stop request from match logic, acts on a tick cycle |
| count_value | output | CNT_W | Timer counter value |
| count_tick | output | 1 | High in a cycle whose next edge advances the counter |

## Verification
The assertions check the per-cycle rules on every clock:
- the counter holds while there is no tick,
- it steps by exactly one after a tick without a clear request,
- it is zero after a reset or a clear request,
- it stays frozen in the halted state,
- a rising-edge source never produces back-to-back events.

Only the bench scenarios can show the behaviours that span many cycles, because they need a reference model:
- the prescale period,
- the two-edge synchronizer latency,
- which input the select field picks,
- the wrap of the counter,
- the release from `ST_HALT` after enable drops.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        SRC_CLOCK = 2'd0,
        SRC_RISE  = 2'd1,
        SRC_FALL  = 2'd2,
        SRC_BOTH  = 2'd3
    } src_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2,
        ST_CLEAR = 2'd3
    } run_state_e;

endpackage

// File: rtl/ptmr_event_src.sv
module ptmr_event_src
    import ptmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int SEL_W = $clog2(NUM_CH),
    localparam int NSLOT = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cap_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  src_mode_e         mode_i,
    output logic              event_o
);

    logic [NUM_CH-1:0] meta_q;
    logic [NUM_CH-1:0] sync_q;
    logic [NSLOT-1:0]  slot;
    logic              pick;
    logic              prev_q;

    // two-flop synchronizer per capture input
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= cap_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign slot = NSLOT'(sync_q);
    assign pick = slot[sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pick;
    end

    always_comb begin
        unique case (mode_i)
            SRC_CLOCK: event_o = 1'b1;
            SRC_RISE:  event_o = pick & ~prev_q;
            SRC_FALL:  event_o = ~pick & prev_q;
            SRC_BOTH:  event_o = pick ^ prev_q;
        endcase
    end

    // R4: a rising edge needs a low sample in between, so two in a row cannot occur
    p_rise_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SRC_RISE && event_o) |=>
            (mode_i != SRC_RISE || !$stable(sel_i) || !event_o));

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         wrap_o
);

    logic [W-1:0] pc_q;

    assign wrap_o = step_i && (pc_q >= limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= '0;
        else if (clr_i)  pc_q <= '0;
        else if (step_i) pc_q <= wrap_o ? '0 : pc_q + W'(1);
    end

    // R3: a wrap leaves the prescale counter at zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> pc_q == '0);

    // R6: no step and no clear, prescale counter holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(pc_q));

endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic inc_i,
    input  logic stop_i,
    output logic active_o,
    output logic halted_o
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_COUNT, ST_CLEAR: begin
                    if (!en_i)                 state_d = ST_IDLE;
                    else if (inc_i && stop_i)  state_d = ST_HALT;
                    else                       state_d = ST_COUNT;
                end
                ST_HALT: begin
                    if (!en_i) state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        active_o = en_i && !clr_i && (state_q != ST_HALT);
        halted_o = (state_q == ST_HALT);
    end

    // R11: a stop request on an advance enters the halted state
    p_stop_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && stop_i && en_i && !clr_i) |=> halted_o);

    // R7: clear always leaves the halted state
    p_clear_unhalts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !halted_o);

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         zero_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] tc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tc_q <= '0;
        else if (clr_i)  tc_q <= '0;
        else if (inc_i)  tc_q <= zero_i ? '0 : tc_q + W'(1);
    end

    assign value_o = tc_q;

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 4,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [SEL_W-1:0]  cfg_src_sel,
    input  logic [CNT_W-1:0]  cfg_prescale,
    input  logic              cnt_en,
    input  logic              cnt_clr,
    input  logic [NUM_CH-1:0] cap_in,
    input  logic              match_clr,
    input  logic              match_stop,
    output logic [CNT_W-1:0]  count_value,
    output logic              count_tick
);

    src_mode_e mode;
    logic      src_event;
    logic      active;
    logic      halted;
    logic      step;
    logic      inc;

    assign mode = src_mode_e'(cfg_mode);
    assign step = active & src_event;

    ptmr_event_src #(.NUM_CH(NUM_CH)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap_in),
        .sel_i   (cfg_src_sel),
        .mode_i  (mode),
        .event_o (src_event)
    );

    ptmr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cnt_en),
        .clr_i    (cnt_clr),
        .inc_i    (inc),
        .stop_i   (match_stop),
        .active_o (active),
        .halted_o (halted)
    );

    ptmr_prescale #(.W(CNT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .step_i  (step),
        .limit_i (cfg_prescale),
        .wrap_o  (inc)
    );

    ptmr_count #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (inc),
        .zero_i  (match_clr),
        .value_o (count_value)
    );

    assign count_tick = inc;

    // R7: clear gives zero at the next edge
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> count_value == '0);

    // R9: no tick, counter holds
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_tick && !cnt_clr) |=> $stable(count_value));

    // R8/R9: a plain tick advances by exactly one, wrapping at all-ones
    p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && !match_clr && !cnt_clr) |=>
            count_value == $past(count_value) + CNT_W'(1));

    // R10: clear request on a tick loads zero
    p_match_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && match_clr) |=> count_value == '0);

    // R6: enable low freezes the counter
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(count_value));

    // R11: halted with no clear, counter frozen
    p_halt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !cnt_clr) |=> $stable(count_value));

endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;

    localparam int TW  = 8;
    localparam int NCH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic [1:0]    sel;
    logic [TW-1:0] ps;
    logic          en, clr, mclr, mstop;
    logic [NCH-1:0] cap;
    logic [TW-1:0] count_value;
    logic          count_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [NCH-1:0] m_s1, m_s2;
    logic           m_prev;
    logic [TW-1:0]  m_pc, m_tc;
    logic           m_halt;

    always #4 clk = ~clk;

    prescaled_timer #(.CNT_W(TW), .NUM_CH(NCH)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (mode),
        .cfg_src_sel  (sel),
        .cfg_prescale (ps),
        .cnt_en       (en),
        .cnt_clr      (clr),
        .cap_in       (cap),
        .match_clr    (mclr),
        .match_stop   (mstop),
        .count_value  (count_value),
        .count_tick   (count_tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_event(input logic [1:0] md, input logic sb, input logic pv);
        case (md)
            2'd0:    return 1'b1;
            2'd1:    return sb & ~pv;
            2'd2:    return ~sb & pv;
            default: return sb ^ pv;
        endcase
    endfunction

    // one clock cycle: inputs were set at the preceding negedge
    task automatic step(input string tag);
        logic sb, ev, act, inc;
        #1;
        sb  = m_s2[sel];
        ev  = model_event(mode, sb, m_prev);
        act = en & ~clr & ~m_halt;
        inc = act & ev & (m_pc >= ps);
        chk({tag, " tick"}, 32'(count_tick), 32'(inc));
        @(posedge clk);
        if (clr) begin
            m_tc = '0; m_pc = '0; m_halt = 1'b0;
        end else begin
            if (act & ev) begin
                if (m_pc >= ps) begin
                    m_pc = '0;
                    m_tc = mclr ? '0 : m_tc + 1'b1;
                end else begin
                    m_pc = m_pc + 1'b1;
                end
            end
            if (!en)              m_halt = 1'b0;
            else if (inc & mstop) m_halt = 1'b1;
        end
        m_prev = sb;
        m_s2   = m_s1;
        m_s1   = cap;
        @(negedge clk);
        chk({tag, " count"}, 32'(count_value), 32'(m_tc));
    endtask

    task automatic run(input string tag, input int n, input bit noise);
        for (int i = 0; i < n; i++) begin
            if (noise) cap = NCH'($urandom);
            step(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; mode = 2'd0; sel = 2'd0; ps = '0;
        en = 1'b0; clr = 1'b0; mclr = 1'b0; mstop = 1'b0; cap = '0;
        m_s1 = '0; m_s2 = '0; m_prev = 1'b0; m_pc = '0; m_tc = '0; m_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset count", 32'(count_value), 32'd0);
        chk("R1 reset tick", 32'(count_tick), 32'd0);

        // R2 clock mode, no prescale
        en = 1'b1;
        run("R2 clock count", 20, 1'b0);

        // R3 prescale 3
        ps = 8'd3;
        run("R3 prescale", 30, 1'b0);
        ps = '0;

        // R12 clock mode ignores noisy capture inputs and select
        sel = 2'd1;
        run("R12 clock ignores caps", 25, 1'b1);

        // R4/R5 rising edges on input 2, other inputs noisy
        mode = 2'd1; sel = 2'd2;
        for (int i = 0; i < 40; i++) begin
            cap = NCH'($urandom);
            cap[2] = (i % 6) < 3;
            step("R4 rising sel2");
        end
        // R5 input 2 held still, others toggling: no counting
        cap[2] = 1'b0;
        for (int i = 0; i < 20; i++) begin
            cap[1:0] = 2'($urandom); cap[3] = 1'($urandom);
            step("R5 unselected ignored");
        end
        // R4 falling edges, select 0
        mode = 2'd2; sel = 2'd0;
        for (int i = 0; i < 40; i++) begin
            cap = NCH'($urandom);
            cap[0] = (i % 4) < 2;
            step("R4 falling sel0");
        end
        // R4 both edges, select 3, with prescale 1
        mode = 2'd3; sel = 2'd3; ps = 8'd1;
        for (int i = 0; i < 40; i++) begin
            cap = NCH'($urandom);
            cap[3] = (i % 5) < 2;
            step("R4 both sel3");
        end

        // R6 enable low freezes, then resume
        mode = 2'd0; ps = 8'd2;
        run("R6 before stop", 5, 1'b0);
        en = 1'b0;
        run("R6 stopped", 10, 1'b1);
        en = 1'b1;
        run("R6 resumed", 10, 1'b0);

        // R7 clear held, overriding enable and match inputs
        clr = 1'b1; mclr = 1'b1; mstop = 1'b1;
        run("R7 clear held", 6, 1'b0);
        clr = 1'b0; mclr = 1'b0; mstop = 1'b0;
        ps = '0;

        // R8 wrap through all-ones
        run("R8 wrap", 300, 1'b0);

        // R10 clear request with random timing
        ps = 8'd1;
        for (int i = 0; i < 40; i++) begin
            mclr = ($urandom_range(0, 3) == 0);
            step("R10 match clear");
        end
        mclr = 1'b0;

        // R11 stop request held: halt, release by dropping enable
        ps = '0;
        mstop = 1'b1;
        run("R11 stop halts", 8, 1'b0);
        mstop = 1'b0;
        run("R11 halted stays", 4, 1'b0);
        en = 1'b0;
        step("R11 release");
        en = 1'b1;
        run("R11 after release", 6, 1'b0);

        // R9 random mix
        for (int i = 0; i < 3000; i++) begin
            mode  = 2'($urandom);
            sel   = 2'($urandom);
            ps    = TW'($urandom_range(0, 3));
            en    = ($urandom_range(0, 9) != 0);
            clr   = ($urandom_range(0, 49) == 0);
            mclr  = ($urandom_range(0, 19) == 0);
            mstop = ($urandom_range(0, 29) == 0);
            cap   = NCH'($urandom);
            step("R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule